// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block keeps a small, fully associative record of loads that were issued early, ahead of stores they might conflict with. When an early load issues, the pipeline inserts the load's destination register number together with its byte address. Every later store presents its address, and any record whose doubleword matches that address is dropped. When the program reaches the point where the early value would be used, it issues a check for the destination register. The block answers, one cycle later, whether the record is still present. A check of load type that misses tells the pipeline to re-execute the load. A check of branch type that misses tells it to branch to recovery code.

The block accepts one insert, one store and one check in every cycle, all at once if needed. There is no back-pressure and no ready signal: each port is a single-cycle valid pulse with its payload. Within one cycle the store is applied first, then the check, then the insert. A check therefore misses if a store hits its doubleword in the same cycle, and an insert in the same cycle as a store or a consuming check always leaves a live record. When every slot is live and a new register is inserted, the record inserted longest ago is replaced. A replaced register then reads as a miss, exactly as if a store had removed it.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset no record is live. Every check misses, and while no response is valid, `rsp_valid`, `rsp_hit`, `rsp_reload` and `rsp_recover` are all 0. Asserting reset later in the run discards every live record.
- R2: After an insert for register r, a check for r answers `rsp_hit`=1 with `rsp_reload`=0 and `rsp_recover`=0.
- R3: A store whose address agrees with a live record's address in all bits above bit 2 (the same 8-byte doubleword) removes that record. A later check of load type (`chk_kind`=0) for that register answers `rsp_reload`=1.
- R4: A store to a different doubleword leaves every record in place.
- R5: A load-type check that hits leaves its record live, so a repeated check hits again.
- R6: A branch-type check (`chk_kind`=1) that hits removes its record, so the next check for that register misses. A branch-type check that misses answers `rsp_recover`=1.
- R7: An insert for a register that already has a live record rewrites that record with the new address. At most one live record exists per register. Afterwards only a store to the new doubleword removes it.
- R8: With all ENTRIES slots live, inserting a register that has no record replaces the record whose insert (or last rewrite) is oldest. All other records stay live.
- R9: A store and a check in the same cycle, where the store hits the checked register's doubleword, produce a miss. A same-cycle store to another doubleword does not affect the check.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `chk_valid`=1. In that cycle exactly one of `rsp_hit`, `rsp_reload`, `rsp_recover` is 1: `rsp_reload` only after a load-type check, `rsp_recover` only after a branch-type check.
- R11: A check for a register that was never inserted misses. The register tag is compared over all REG_W bits.
- R12: When a free slot exists, an insert fills it and replaces no live record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Early load issues this cycle |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| st_valid | input | 1 | Store issues this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check issues this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_kind | input | 1 | 0 = load-type check, 1 = branch-type check |
| rsp_valid | output | 1 | Check answer valid (one cycle after chk_valid) |
| rsp_hit | output | 1 | Early value still valid |
| rsp_reload | output | 1 | Load-type check missed: reload needed |
| rsp_recover | output | 1 | Branch-type check missed: go to recovery |

## Verification
The main lookup is driven from a vector table. The table covers stores to the same doubleword at different byte offsets, which must remove the record, against stores to neighbouring doublewords, which must not. It covers repeated load-type checks, which must keep hitting, against branch-type checks, which hit once and then miss. It covers a rewrite of the same register followed by stores to the old and then the new address, which tells the rewrite apart from a second record. Same-cycle store and check pairs, with and without a doubleword match, separate the stated ordering from the opposite one. Directed runs then fill all slots, add one more register and free one slot before a further insert. Together they show that the oldest insert, and only that one, is replaced, and that a free slot is used before any live record is.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;
  typedef enum logic {
    CHK_LOAD   = 1'b0,
    CHK_BRANCH = 1'b1
  } chk_kind_e;
endpackage

// File: rtl/slt_match.sv
// Parallel compare of every slot against the three request ports.
module slt_match #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int DW_W    = 29
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][REG_W-1:0]  tag,
  input  logic [ENTRIES-1:0][DW_W-1:0]   dw,
  input  logic [REG_W-1:0]               ins_reg,
  input  logic [REG_W-1:0]               chk_reg,
  input  logic                           st_valid,
  input  logic [DW_W-1:0]                st_dw,
  output logic [ENTRIES-1:0]             ins_match,
  output logic [ENTRIES-1:0]             chk_match,
  output logic [ENTRIES-1:0]             st_kill
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign ins_match[e] = valid[e] && (tag[e] == ins_reg);
    assign chk_match[e] = valid[e] && (tag[e] == chk_reg);
    assign st_kill[e]   = valid[e] && st_valid && (dw[e] == st_dw);
  end
endmodule

// File: rtl/slt_age.sv
// Insert-order matrix: older[i][j] = 1 means slot i was written before slot j.
module slt_age #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [ENTRIES-1:0] oldest
);
  logic [ENTRIES-1:0][ENTRIES-1:0] older;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        for (int j = 0; j < ENTRIES; j++)
          older[i][j] <= (i < j);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++)
        for (int j = 0; j < ENTRIES; j++) begin
          if (touch_idx == IDX_W'(i))
            older[i][j] <= 1'b0;
          else if (touch_idx == IDX_W'(j))
            older[i][j] <= 1'b1;
        end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      oldest[i] = valid[i];
      for (int j = 0; j < ENTRIES; j++)
        if (j != i && valid[j] && !older[i][j])
          oldest[i] = 1'b0;
    end
  end
endmodule

// File: rtl/slt_victim.sv
// Slot choice for an insert: same register, else lowest free, else oldest.
module slt_victim #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] same_reg,
  input  logic [ENTRIES-1:0] oldest,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] same_idx, free_idx, old_idx;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_reg[i]) same_idx = IDX_W'(i);
      if (!valid[i])   free_idx = IDX_W'(i);
      if (oldest[i])   old_idx  = IDX_W'(i);
    end
    if (|same_reg)     idx = same_idx;
    else if (!(&valid)) idx = free_idx;
    else               idx = old_idx;
  end
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
  import spec_load_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int REG_W     = 7,
  parameter int ADDR_W    = 32,
  parameter int GRAIN_LOG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_kind,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_reload,
  output logic              rsp_recover
);
  localparam int DW_W  = ADDR_W - GRAIN_LOG;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][REG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DW_W-1:0]   dw_q;

  logic [DW_W-1:0] ins_dw, st_dw;
  logic            unused_grain_bits;
  assign ins_dw            = ins_addr[ADDR_W-1:GRAIN_LOG];
  assign st_dw             = st_addr[ADDR_W-1:GRAIN_LOG];
  assign unused_grain_bits = ^{ins_addr[GRAIN_LOG-1:0], st_addr[GRAIN_LOG-1:0]};

  logic [ENTRIES-1:0] ins_match, chk_match, st_kill, oldest;
  logic [IDX_W-1:0]   victim;

  slt_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .DW_W(DW_W)) u_match (
    .valid    (valid_q),
    .tag      (tag_q),
    .dw       (dw_q),
    .ins_reg  (ins_reg),
    .chk_reg  (chk_reg),
    .st_valid (st_valid),
    .st_dw    (st_dw),
    .ins_match(ins_match),
    .chk_match(chk_match),
    .st_kill  (st_kill)
  );

  slt_age #(.ENTRIES(ENTRIES)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch    (ins_valid),
    .touch_idx(victim),
    .valid    (valid_q),
    .oldest   (oldest)
  );

  slt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid   (valid_q),
    .same_reg(ins_match),
    .oldest  (oldest),
    .idx     (victim)
  );

  // Order inside one cycle: store, then check, then insert.
  logic [ENTRIES-1:0] live_hit, consume, valid_d;
  logic               is_branch, lookup_hit;

  assign is_branch  = (chk_kind_e'(chk_kind) == CHK_BRANCH);
  assign live_hit   = chk_match & ~st_kill;
  assign lookup_hit = |live_hit;
  assign consume    = (chk_valid && is_branch) ? live_hit : '0;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (ins_valid && victim == IDX_W'(e))
        valid_d[e] = 1'b1;
      else
        valid_d[e] = valid_q[e] & ~st_kill[e] & ~consume[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      tag_q[victim] <= ins_reg;
      dw_q[victim]  <= ins_dw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_reload  <= 1'b0;
      rsp_recover <= 1'b0;
    end else begin
      rsp_valid   <= chk_valid;
      rsp_hit     <= chk_valid && lookup_hit;
      rsp_reload  <= chk_valid && !lookup_hit && !is_branch;
      rsp_recover <= chk_valid && !lookup_hit && is_branch;
    end
  end
endmodule

// File: rtl/spec_load_tracker_chk.sv
module spec_load_tracker_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               st_valid,
  input logic               chk_valid,
  input logic               chk_kind,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_reload,
  input logic               rsp_recover,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] chk_match
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, rsp_reload, rsp_recover} == 3'b000));

  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(chk_valid)));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_reload, rsp_recover}) == 1));

  assert_reload_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_reload) |-> ($past(chk_kind) == 1'b0));

  assert_recover_after_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_recover) |-> ($past(chk_kind) == 1'b1));

  assert_single_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_match));

  assert_full_stays_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_q) && ins_valid && !st_valid && !chk_valid) |=> (&valid_q));
endmodule

bind spec_load_tracker spec_load_tracker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid),
  .st_valid   (st_valid),
  .chk_valid  (chk_valid),
  .chk_kind   (chk_kind),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_reload (rsp_reload),
  .rsp_recover(rsp_recover),
  .valid_q    (valid_q),
  .chk_match  (chk_match)
);

// File: tb/spec_load_tracker_bench.sv
module spec_load_tracker_bench;
  localparam int CLK_P  = 10;
  localparam int REG_W  = 7;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ins_valid, st_valid, chk_valid, chk_kind;
  logic [REG_W-1:0]  ins_reg, chk_reg;
  logic [ADDR_W-1:0] ins_addr, st_addr;
  logic              rsp_valid, rsp_hit, rsp_reload, rsp_recover;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  spec_load_tracker u_spec_load_tracker (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_kind(chk_kind),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_reload(rsp_reload), .rsp_recover(rsp_recover)
  );

  typedef struct packed {
    logic              iv;
    logic [REG_W-1:0]  ir;
    logic [ADDR_W-1:0] ia;
    logic              sv;
    logic [ADDR_W-1:0] sa;
    logic              cv;
    logic [REG_W-1:0]  cr;
    logic              ck;
    logic              eh;
    logic              er;
    logic              ec;
  } vec_t;

  localparam int NV = 18;
  // Fields: ins v/reg/addr, store v/addr, check v/reg/kind, expected hit/reload/recover.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd5, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 never inserted
    '{1'b1, 7'd5, 32'h100, 1'b0, 32'h0,   1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd5, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd5, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    '{1'b0, 7'd0, 32'h0,   1'b1, 32'h108, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 neighbour dw
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd5, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    '{1'b0, 7'd0, 32'h0,   1'b1, 32'h107, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 same dw
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd5, 1'b0, 1'b0, 1'b1, 1'b0}, // R3
    '{1'b1, 7'd6, 32'h300, 1'b0, 32'h0,   1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd6, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 hit
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd6, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 consumed
    '{1'b1, 7'd7, 32'h400, 1'b0, 32'h0,   1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 7'd7, 32'h500, 1'b0, 32'h0,   1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 rewrite
    '{1'b0, 7'd0, 32'h0,   1'b1, 32'h400, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 7'd0, 32'h0,   1'b0, 32'h0,   1'b1, 7'd7, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 old addr ignored
    '{1'b0, 7'd0, 32'h0,   1'b1, 32'h504, 1'b1, 7'd7, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 same cycle kill
    '{1'b1, 7'd8, 32'h600, 1'b0, 32'h0,   1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 7'd0, 32'h0,   1'b1, 32'h610, 1'b1, 7'd8, 1'b1, 1'b1, 1'b0, 1'b0}  // R9 other dw
  };

  task automatic drive(input logic iv, input logic [REG_W-1:0] ir, input logic [ADDR_W-1:0] ia,
                       input logic sv, input logic [ADDR_W-1:0] sa,
                       input logic cv, input logic [REG_W-1:0] cr, input logic ck);
    @(negedge clk);
    ins_valid = iv; ins_reg = ir; ins_addr = ia;
    st_valid  = sv; st_addr = sa;
    chk_valid = cv; chk_reg = cr; chk_kind = ck;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rsp(input string req, input logic ev, input logic eh,
                            input logic er, input logic ec);
    tests++;
    if ({rsp_valid, rsp_hit, rsp_reload, rsp_recover} !== {ev, eh, er, ec}) begin
      fails++;
      $display("FAIL %s: valid/hit/reload/recover got %b%b%b%b expected %b%b%b%b",
               req, rsp_valid, rsp_hit, rsp_reload, rsp_recover, ev, eh, er, ec);
    end
  endtask

  task automatic insert(input logic [REG_W-1:0] r, input logic [ADDR_W-1:0] a);
    drive(1'b1, r, a, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic check(input logic [REG_W-1:0] r, input logic k);
    drive(1'b0, '0, '0, 1'b0, '0, 1'b1, r, k);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ins_valid = 1'b0; ins_reg = '0; ins_addr = '0;
    st_valid = 1'b0; st_addr = '0;
    chk_valid = 1'b0; chk_reg = '0; chk_kind = 1'b0;
    apply_reset();
    #1;
    expect_rsp("R1 reset outputs", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].iv, VECS[i].ir, VECS[i].ia, VECS[i].sv, VECS[i].sa,
            VECS[i].cv, VECS[i].cr, VECS[i].ck);
      if (VECS[i].cv)
        expect_rsp($sformatf("table row %0d", i), 1'b1, VECS[i].eh, VECS[i].er, VECS[i].ec);
    end

    // R10: no check -> no response the cycle after
    drive(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
    expect_rsp("R10 idle cycle", 1'b0, 1'b0, 1'b0, 1'b0);

    // R11: tag differing only in the top bit
    insert(7'h03, 32'h900);
    check(7'h43, 1'b0);
    expect_rsp("R11 top tag bit", 1'b1, 1'b0, 1'b1, 1'b0);

    // R1: reset mid-run drops records
    insert(7'd9, 32'h700);
    check(7'd9, 1'b0);
    expect_rsp("R1 before reset", 1'b1, 1'b1, 1'b0, 1'b0);
    apply_reset();
    check(7'd9, 1'b0);
    expect_rsp("R1 after reset", 1'b1, 1'b0, 1'b1, 1'b0);
    check(7'd3, 1'b1);
    expect_rsp("R1 after reset branch", 1'b1, 1'b0, 1'b0, 1'b1);

    // R8: fill all 16 slots, then one more
    apply_reset();
    for (int k = 10; k < 26; k++) insert(REG_W'(k), ADDR_W'(k) << 12);
    insert(7'd26, 32'h1A000);
    check(7'd10, 1'b0);
    expect_rsp("R8 oldest replaced", 1'b1, 1'b0, 1'b1, 1'b0);
    check(7'd11, 1'b0);
    expect_rsp("R8 next oldest kept", 1'b1, 1'b1, 1'b0, 1'b0);
    check(7'd25, 1'b0);
    expect_rsp("R8 youngest kept", 1'b1, 1'b1, 1'b0, 1'b0);
    check(7'd26, 1'b0);
    expect_rsp("R8 new record", 1'b1, 1'b1, 1'b0, 1'b0);

    // R12: free a slot, insert fills it without replacing reg 11
    drive(1'b0, '0, '0, 1'b1, 32'hC003, 1'b0, '0, 1'b0);
    insert(7'd27, 32'h1B000);
    check(7'd11, 1'b0);
    expect_rsp("R12 oldest survives", 1'b1, 1'b1, 1'b0, 1'b0);
    check(7'd27, 1'b0);
    expect_rsp("R12 inserted", 1'b1, 1'b1, 1'b0, 1'b0);
    check(7'd12, 1'b0);
    expect_rsp("R12 freed slot gone", 1'b1, 1'b0, 1'b1, 1'b0);
    check(7'd13, 1'b0);
    expect_rsp("R12 neighbour kept", 1'b1, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule